// File: doc/BRIEF.md
# Half-Split Bank Mapper

This block maps a 16-bit CPU address space onto a larger physical ROM and a larger physical RAM. The CPU space is cut in two halves. The upper half (addresses with bit 15 set) always reaches the same common 32 KB block of RAM. The lower half is a banked window. A bank register picks which 32 KB block of ROM or of RAM appears there.

The CPU loads the bank register with a single I/O write to a decoded port. Reset clears the register, so the first ROM block sits in the lower window and the CPU can start from it. After the boot code has copied what it needs into common RAM, one more I/O write swaps RAM into the window. An optional second register holds a separate write bank. Memory writes in the lower window then follow it, and reads and idle cycles follow the read bank. This lets a plain block-move loop copy data from one bank to another.

Top module: `half_split_mapper`

## Requirements
- R1: After reset both bank registers are zero. A memory access to the lower half then selects ROM, with phys_addr equal to the CPU address with bit 15 cleared.
- R2: A memory access with cpu_addr[15]=1 asserts ram_cs_n and deasserts rom_cs_n, whatever the register contents. phys_addr is then {4'b0000, cpu_addr[14:0]}, which is the common block 0.
- R3: A memory access in the lower half drives phys_addr = {bank[3:0], cpu_addr[14:0]}, where bank is the selected register.
- R4: Bit 6 of the selected register picks RAM (1) or ROM (0) for the lower half. Bits 4, 5 and 7 have no effect on the mapping. For example, 41h gives RAM block 1 and 01h gives ROM block 1.
- R5: An I/O write (iorq_n=0, wr_n=0) with cpu_addr[7:0]=40h loads cpu_data into both the read and the write bank registers at the next clock edge. The new mapping applies from the following cycle.
- R6: An I/O write with cpu_addr[7:0]=41h loads only the write bank register. The read bank is left unchanged.
- R7: In the lower half, a memory cycle with wr_n=0 uses the write bank. A cycle with rd_n=0, or with neither strobe low, uses the read bank.
- R8: With mreq_n=1 neither chip select is asserted, and no cycle asserts both.
- R9: I/O reads, I/O writes to other port addresses and memory writes leave both bank registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address bus; bits 7:0 carry the I/O port number |
| cpu_data | input | 8 | CPU data bus as seen on a write |
| mreq_n | input | 1 | Active-low memory request |
| iorq_n | input | 1 | Active-low I/O request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| phys_addr | output | 19 | Physical address: 4-bit block number and 15-bit offset |
| rom_cs_n | output | 1 | Active-low ROM chip select |
| ram_cs_n | output | 1 | Active-low RAM chip select |

## Verification
The address and chip-select outputs are combinational from the bus inputs and the registers. The bench therefore drives each vector after a falling edge and compares the outputs two time units later, still before the next rising edge. A register load is due at the rising edge that follows the I/O write. The bench updates its own model of both registers only after that edge, so the first vector that can see a new bank is the next one. Directed sequences cover reset, the 41h and 01h values, the ignored bits, split read and write banks, and I/O writes that must not load. Seeded random cycles mix all bus kinds.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    typedef logic [7:0] bank_t;

    typedef struct packed {
        bank_t rd;
        bank_t wr;
    } bank_pair_t;
endpackage

// File: rtl/mmu_port_decode.sv
module mmu_port_decode #(
    parameter logic [7:0] PORT_MAIN = 8'h40,
    parameter logic [7:0] PORT_WRB  = 8'h41,
    parameter bit         SPLIT_WR  = 1'b1
) (
    input  logic [7:0] io_port,
    input  logic       iorq_n,
    input  logic       wr_n,
    output logic       ld_both,
    output logic       ld_wr
);
    logic io_write;
    assign io_write = !iorq_n && !wr_n;
    assign ld_both  = io_write && (io_port == PORT_MAIN);

    generate
        if (SPLIT_WR) begin : g_split
            assign ld_wr = io_write && (io_port == PORT_WRB);
        end else begin : g_single
            assign ld_wr = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mmu_bank_latch.sv
module mmu_bank_latch
    import mmu_pkg::*;
#(
    parameter bit SPLIT_WR = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_both,
    input  logic       ld_wr,
    input  bank_t      din,
    output bank_pair_t bank_q
);
    bank_pair_t bank_d;

    always_comb begin
        bank_d = bank_q;
        if (ld_both) begin
            bank_d.rd = din;
            bank_d.wr = din;
        end else if (ld_wr && SPLIT_WR) begin
            bank_d.wr = din;
        end
        if (!SPLIT_WR) begin
            bank_d.wr = bank_d.rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    p_load_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_both |=> (bank_q.rd == $past(din) && bank_q.wr == $past(din)));

    p_wr_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr && !ld_both) |=> $stable(bank_q.rd));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_both && !ld_wr) |=> $stable(bank_q));
endmodule

// File: rtl/mmu_window_xlate.sv
module mmu_window_xlate
    import mmu_pkg::*;
#(
    parameter int          BLK_BITS   = 4,
    parameter int          SEL_BIT    = 6,
    parameter int          OFF_BITS   = 15,
    parameter int unsigned COMMON_BLK = 0,
    localparam int         PA_W       = BLK_BITS + OFF_BITS
) (
    input  logic [15:0]    cpu_addr,
    input  logic           mreq_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  bank_pair_t     bank_q,
    output logic [PA_W-1:0] phys_addr,
    output logic           rom_cs_n,
    output logic           ram_cs_n
);
    bank_t sel;
    logic  upper;
    logic  unused_rd_n;

    assign unused_rd_n = rd_n;
    assign upper       = cpu_addr[15];

    always_comb begin
        sel = (!wr_n) ? bank_q.wr : bank_q.rd;
        rom_cs_n = 1'b1;
        ram_cs_n = 1'b1;
        if (upper) begin
            phys_addr = {BLK_BITS'(COMMON_BLK), cpu_addr[OFF_BITS-1:0]};
            ram_cs_n  = mreq_n;
        end else begin
            phys_addr = {sel[BLK_BITS-1:0], cpu_addr[OFF_BITS-1:0]};
            if (sel[SEL_BIT]) begin
                ram_cs_n = mreq_n;
            end else begin
                rom_cs_n = mreq_n;
            end
        end
    end
endmodule

// File: rtl/half_split_mapper.sv
module half_split_mapper
    import mmu_pkg::*;
#(
    parameter int         BLK_BITS  = 4,
    parameter int         SEL_BIT   = 6,
    parameter logic [7:0] PORT_MAIN = 8'h40,
    parameter logic [7:0] PORT_WRB  = 8'h41,
    parameter bit         SPLIT_WR  = 1'b1,
    localparam int        OFF_BITS  = 15,
    localparam int        PA_W      = BLK_BITS + OFF_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     cpu_addr,
    input  logic [7:0]      cpu_data,
    input  logic            mreq_n,
    input  logic            iorq_n,
    input  logic            rd_n,
    input  logic            wr_n,
    output logic [PA_W-1:0] phys_addr,
    output logic            rom_cs_n,
    output logic            ram_cs_n
);
    logic       ld_both;
    logic       ld_wr;
    bank_pair_t bank_q;

    mmu_port_decode #(
        .PORT_MAIN (PORT_MAIN),
        .PORT_WRB  (PORT_WRB),
        .SPLIT_WR  (SPLIT_WR)
    ) u_dec (
        .io_port (cpu_addr[7:0]),
        .iorq_n  (iorq_n),
        .wr_n    (wr_n),
        .ld_both (ld_both),
        .ld_wr   (ld_wr)
    );

    mmu_bank_latch #(
        .SPLIT_WR (SPLIT_WR)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_both (ld_both),
        .ld_wr   (ld_wr),
        .din     (cpu_data),
        .bank_q  (bank_q)
    );

    mmu_window_xlate #(
        .BLK_BITS   (BLK_BITS),
        .SEL_BIT    (SEL_BIT),
        .OFF_BITS   (OFF_BITS),
        .COMMON_BLK (0)
    ) u_xlate (
        .cpu_addr  (cpu_addr),
        .mreq_n    (mreq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .bank_q    (bank_q),
        .phys_addr (phys_addr),
        .rom_cs_n  (rom_cs_n),
        .ram_cs_n  (ram_cs_n)
    );

    p_cs_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_cs_n && !ram_cs_n));

    p_idle_no_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> (rom_cs_n && ram_cs_n));

    p_upper_common_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && cpu_addr[15]) |->
            (!ram_cs_n && phys_addr[PA_W-1:OFF_BITS] == '0));
endmodule

// File: tb/half_split_mapper_tb.sv
module half_split_mapper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        mreq_n = 1'b1;
    logic        iorq_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [18:0] phys_addr;
    logic        rom_cs_n;
    logic        ram_cs_n;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] m_rd = 8'h00;
    logic [7:0] m_wr = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    half_split_mapper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .mreq_n    (mreq_n),
        .iorq_n    (iorq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .phys_addr (phys_addr),
        .rom_cs_n  (rom_cs_n),
        .ram_cs_n  (ram_cs_n)
    );

    // expected {phys, rom_cs_n, ram_cs_n}
    function automatic logic [20:0] expect_out(logic [15:0] a, logic mq, logic w);
        logic [7:0]  b;
        logic [18:0] p;
        logic        rom, ram;
        b = (!w) ? m_wr : m_rd;
        rom = 1'b1;
        ram = 1'b1;
        if (a[15]) begin
            p = {4'h0, a[14:0]};
            ram = mq;
        end else begin
            p = {b[3:0], a[14:0]};
            if (b[6]) ram = mq; else rom = mq;
        end
        return {p, rom, ram};
    endfunction

    task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic mq,
                       input logic iq, input logic r, input logic w, input string tag);
        logic [20:0] e;
        @(negedge clk);
        cpu_addr = a; cpu_data = d; mreq_n = mq; iorq_n = iq; rd_n = r; wr_n = w;
        #2;
        e = expect_out(a, mq, w);
        vectors++;
        if (mq) begin
            if ({rom_cs_n, ram_cs_n} != 2'b11) begin
                errors++;
                $display("FAIL %s cs actual=%b expected=11", tag, {rom_cs_n, ram_cs_n});
            end
        end else if ({phys_addr, rom_cs_n, ram_cs_n} != e) begin
            errors++;
            $display("FAIL %s actual phys=%h cs=%b expected phys=%h cs=%b",
                     tag, phys_addr, {rom_cs_n, ram_cs_n}, e[20:2], e[1:0]);
        end
        @(posedge clk);
        if (!iq && !w) begin
            if (a[7:0] == 8'h40) begin m_rd = d; m_wr = d; end
            else if (a[7:0] == 8'h41) m_wr = d;
        end
    endtask

    task automatic io_wr(input logic [7:0] port, input logic [7:0] d, input string tag);
        cyc({8'h00, port}, d, 1'b1, 1'b0, 1'b1, 1'b0, tag);
    endtask

    task automatic mem_rd(input logic [15:0] a, input string tag);
        cyc(a, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, tag);
    endtask

    task automatic mem_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        cyc(a, d, 1'b0, 1'b1, 1'b1, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset maps ROM block 0 in the low window
        mem_rd(16'h1234, "R1");
        mem_rd(16'h7FFF, "R1");
        // R2: upper half is common RAM
        mem_rd(16'hC0DE, "R2");
        // R5/R4: 41h gives RAM block 1
        io_wr(8'h40, 8'h41, "R5");
        mem_rd(16'h0100, "R5");
        mem_wr(16'h0200, 8'hAA, "R4");
        // R4: 01h gives ROM block 1
        io_wr(8'h40, 8'h01, "R4");
        mem_rd(16'h0300, "R4");
        // R4: bits 4,5,7 have no effect
        io_wr(8'h40, 8'hB5, "R4");
        mem_rd(16'h2345, "R4");
        // R6: split write bank, read bank unchanged
        io_wr(8'h40, 8'h42, "R6");
        io_wr(8'h41, 8'h07, "R6");
        mem_rd(16'h4000, "R6");
        // R7: write cycle in low half uses write bank, idle strobes read bank
        mem_wr(16'h4001, 8'h55, "R7");
        cyc(16'h4002, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
        // R2: upper half ignores banks even while split
        mem_wr(16'h8001, 8'h11, "R2");
        // R9: I/O read, other port, memory write to port-like address
        cyc(16'h0040, 8'h4F, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        io_wr(8'h42, 8'h4F, "R9");
        mem_wr(16'h0040, 8'h4F, "R9");
        mem_rd(16'h0500, "R9");
        mem_wr(16'h0501, 8'h00, "R9");
        // R8: no memory request
        cyc(16'h0600, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
        cyc(16'h9000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, "R8");

        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int          k;
            string       tag;
            a = 16'($urandom);
            d = 8'($urandom);
            k = int'($urandom % 8);
            case (k)
                0: io_wr(8'h40, d, "R5");
                1: io_wr(8'h41, d, "R6");
                2: io_wr(8'($urandom), d, "R9");
                3: cyc(a, d, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
                4: cyc(a, d, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
                5: begin
                    tag = a[15] ? "R2" : "R7";
                    mem_wr(a, d, tag);
                end
                default: begin
                    tag = a[15] ? "R2" : "R3";
                    mem_rd(a, tag);
                end
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule